// File: doc/BRIEF.md
# T1 Receive Alarm Detector

This block watches a recovered T1 receive stream, one bit per strobe, and drives three level alarm flags. Each bit comes with its own markers: a frame-bit flag, the index of the 8-bit channel time slot and the position of the bit inside that slot, and a flag for bits that belong to the facility data link. The framer also supplies a mode select (ESF or D4 superframe) and an out-of-frame flag. Frame alignment, line decoding and register access are done elsewhere.

A frame runs from one frame bit up to the next frame bit. It is judged when the following frame bit arrives. The D4 yellow alarm looks at the second bit of every channel. The ESF yellow alarm looks for a 16-bit data-link pattern. The blue alarm detects an all-ones (AIS) signal received while the framer has lost alignment, and it drops as soon as any zero arrives.

Top module: `t1_alarm_mon`

## Requirements
- R1: A synchronous active-high reset clears all three alarm flags, the data-link history and the frame counters, and all three outputs read 0 on the cycle after reset.
- R2: A frame starts at a strobed bit with the frame-bit flag set. The bit-position code counts from 0 for the first-received (most significant) bit, so bit 2 of a slot is code 1. In D4 mode, the D4 yellow flag goes to 1 on the cycle after the next frame bit when, in the preceding complete frame, bit 2 was received in all 24 channels and was 0 in every one of them.
- R3: The D4 yellow flag goes to 0 on the cycle after the frame bit that ends the first frame in which any channel carried bit 2 equal to 1.
- R4: While ESF mode is selected, the D4 yellow flag reads 0 whatever the payload carries.
- R5: In ESF mode, each strobed bit with the data-link flag set is shifted into a 16-bit history, newest bit last. When 16 such bits have been seen and the last 16 are eight ones followed by eight zeros, the ESF yellow flag goes to 1 on the next cycle.
- R6: The ESF yellow flag goes to 0 once 16 consecutive data-link bits have arrived with no pattern match.
- R7: Outside ESF mode, data-link bits are ignored: the ESF yellow flag reads 0, and leaving ESF mode discards the data-link history, so a match needs 16 fresh bits after ESF mode returns.
- R8: The blue flag goes to 1 when the last two complete frames, frame bits included, were all ones with no zero since, and the out-of-frame input is high.
- R9: The blue flag stays 0 while the out-of-frame input is low, however many all-ones frames arrive.
- R10: A received zero bit clears the blue flag on the next cycle and restarts the all-ones frame count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_vld | input | 1 | Strobe: a received bit is present this cycle |
| rx_bit | input | 1 | Received data bit |
| frm_bit | input | 1 | The strobed bit is the frame bit that starts a frame |
| slot_idx | input | 5 | Channel time slot of the strobed payload bit (0 to 23) |
| bit_pos | input | 3 | Position in the slot, 0 = first received |
| esf_mode | input | 1 | 1 = ESF superframe, 0 = D4 superframe |
| fdl_pos | input | 1 | The strobed bit is a data-link bit |
| oof | input | 1 | Out-of-frame flag from the framer |
| yel_d4 | output | 1 | D4 yellow alarm (bit 2 of every channel is zero) |
| yel_esf | output | 1 | ESF yellow alarm (data-link pattern) |
| blue | output | 1 | Blue alarm (all ones while out of frame) |

## Verification
The bench keeps the default parameters: 24 channels of 8 bits, a 16-bit data-link pattern made of two runs of eight, and a two-frame all-ones threshold. With one bit per clock, a full 193-bit frame takes about 195 cycles. This allows long runs of frames, including the 32 ESF frames needed to fill the data-link history and the 32 more needed to clear it. Random payloads, with bit 2 either forced or left free, are mixed with directed all-ones frames, mode switches and single injected zero bits at the edges of the blue window.

// File: rtl/t1am_pkg.sv
package t1am_pkg;
  // Build the data-link alarm pattern: RUN ones (oldest) then RUN zeros.
  function automatic logic [63:0] fdl_alarm_pattern(input int run);
    logic [63:0] p;
    p = '0;
    for (int i = 0; i < 2 * run; i++) begin
      if (i >= run) p[i] = 1'b1;
    end
    return p;
  endfunction
endpackage

// File: rtl/t1am_frame_track.sv
module t1am_frame_track (
  input  logic clk,
  input  logic rst,
  input  logic bit_vld,
  input  logic frm_bit,
  output logic frm_end
);
  logic started_q;

  always_ff @(posedge clk) begin
    if (rst) started_q <= 1'b0;
    else if (bit_vld && frm_bit) started_q <= 1'b1;
  end

  // A frame bit closes the previous frame only once one frame has begun.
  assign frm_end = bit_vld && frm_bit && started_q;
endmodule

// File: rtl/t1am_d4_yellow.sv
module t1am_d4_yellow #(
  parameter int CHANNELS  = 24,
  parameter int SLOT_BITS = 8,
  parameter int YEL_BIT   = 2,
  localparam int SLOT_W   = $clog2(CHANNELS),
  localparam int POS_W    = $clog2(SLOT_BITS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_vld,
  input  logic              rx_bit,
  input  logic              frm_bit,
  input  logic              frm_end,
  input  logic [SLOT_W-1:0] slot_idx,
  input  logic [POS_W-1:0]  bit_pos,
  input  logic              esf_mode,
  output logic              yel
);
  localparam int CNT_W = $clog2(CHANNELS + 1);
  localparam logic [POS_W-1:0] YEL_CODE = POS_W'(YEL_BIT - 1);

  logic [CNT_W-1:0] seen_q;
  logic             one_q;
  logic             yel_q;
  logic             tap;

  assign tap = bit_vld && !frm_bit && (bit_pos == YEL_CODE) &&
               (32'(slot_idx) < CHANNELS);

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q <= '0;
      one_q  <= 1'b0;
    end else if (bit_vld && frm_bit) begin
      seen_q <= '0;
      one_q  <= 1'b0;
    end else if (tap) begin
      if (32'(seen_q) < CHANNELS) seen_q <= seen_q + 1'b1;
      one_q <= one_q | rx_bit;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || esf_mode) yel_q <= 1'b0;
    else if (frm_end) begin
      if (one_q) yel_q <= 1'b0;
      else if (32'(seen_q) == CHANNELS) yel_q <= 1'b1;
    end
  end

  assign yel = yel_q;

  // R2: the flag only rises on a frame boundary
  a_r2_rise_at_frame_end: assert property (@(posedge clk) disable iff (rst)
    $rose(yel_q) |-> $past(frm_end));
  // R3: the flag only falls on a boundary or by a mode change
  a_r3_fall_at_frame_end: assert property (@(posedge clk) disable iff (rst)
    $fell(yel_q) |-> ($past(frm_end) || $past(esf_mode)));
  // R4: ESF mode holds the D4 flag low
  a_r4_quiet_in_esf: assert property (@(posedge clk) disable iff (rst)
    esf_mode |=> !yel_q);
endmodule

// File: rtl/t1am_esf_yellow.sv
module t1am_esf_yellow #(
  parameter int FDL_RUN = 8,
  localparam int PAT_W  = 2 * FDL_RUN,
  localparam int GAP_W  = $clog2(PAT_W + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_vld,
  input  logic rx_bit,
  input  logic fdl_pos,
  input  logic esf_mode,
  output logic yel
);
  import t1am_pkg::*;
  localparam logic [63:0]      PAT_FULL = fdl_alarm_pattern(FDL_RUN);
  localparam logic [PAT_W-1:0] PATTERN  = PAT_FULL[PAT_W-1:0];

  logic [PAT_W-1:0] hist_q, hist_n;
  logic [GAP_W-1:0] fill_q, fill_n, gap_q, gap_n;
  logic             yel_q;
  logic             stb, hit;

  assign stb    = bit_vld && fdl_pos && esf_mode;
  assign hist_n = {hist_q[PAT_W-2:0], rx_bit};
  assign fill_n = (32'(fill_q) < PAT_W) ? fill_q + 1'b1 : fill_q;
  assign gap_n  = (32'(gap_q) < PAT_W) ? gap_q + 1'b1 : gap_q;
  assign hit    = (32'(fill_n) == PAT_W) && (hist_n == PATTERN);

  always_ff @(posedge clk) begin
    if (rst || !esf_mode) begin
      hist_q <= '0;
      fill_q <= '0;
      gap_q  <= '0;
      yel_q  <= 1'b0;
    end else if (stb) begin
      hist_q <= hist_n;
      fill_q <= fill_n;
      if (hit) begin
        yel_q <= 1'b1;
        gap_q <= '0;
      end else begin
        gap_q <= gap_n;
        if (32'(gap_n) == PAT_W) yel_q <= 1'b0;
      end
    end
  end

  assign yel = yel_q;

  // R5: the flag rises only on a data-link bit in ESF mode
  a_r5_rise_on_fdl: assert property (@(posedge clk) disable iff (rst)
    $rose(yel_q) |-> $past(bit_vld && fdl_pos && esf_mode));
  // R7: outside ESF mode the flag stays low
  a_r7_quiet_in_d4: assert property (@(posedge clk) disable iff (rst)
    !esf_mode |=> !yel_q);
  // R6: a drop happens only on a data-link bit or a mode change
  a_r6_fall_on_fdl: assert property (@(posedge clk) disable iff (rst)
    $fell(yel_q) |-> ($past(bit_vld && fdl_pos) || $past(!esf_mode)));
endmodule

// File: rtl/t1am_blue.sv
module t1am_blue #(
  parameter int BLUE_FRAMES = 2,
  localparam int RUN_W = $clog2(BLUE_FRAMES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_vld,
  input  logic rx_bit,
  input  logic frm_bit,
  input  logic frm_end,
  input  logic oof,
  output logic blue
);
  logic [RUN_W-1:0] run_q;
  logic             ones_q;
  logic             blue_q;
  logic             zero_now;

  assign zero_now = bit_vld && !rx_bit;

  // Per-frame all-ones tracker, frame bit included.
  always_ff @(posedge clk) begin
    if (rst) ones_q <= 1'b0;
    else if (bit_vld && frm_bit) ones_q <= rx_bit;
    else if (bit_vld) ones_q <= ones_q & rx_bit;
  end

  always_ff @(posedge clk) begin
    if (rst || zero_now) run_q <= '0;
    else if (frm_end) begin
      if (!ones_q) run_q <= '0;
      else if (32'(run_q) < BLUE_FRAMES) run_q <= run_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || zero_now) blue_q <= 1'b0;
    else if ((32'(run_q) == BLUE_FRAMES) && oof) blue_q <= 1'b1;
  end

  assign blue = blue_q;

  // R10: a zero bit clears the alarm on the next cycle
  a_r10_zero_clears: assert property (@(posedge clk) disable iff (rst)
    (bit_vld && !rx_bit) |=> !blue_q);
  // R8: the alarm rises only while out of frame
  a_r8_needs_oof: assert property (@(posedge clk) disable iff (rst)
    $rose(blue_q) |-> $past(oof));
  // R9: the alarm never rises while in frame
  a_r9_no_rise_in_frame: assert property (@(posedge clk) disable iff (rst)
    !oof |=> !$rose(blue_q));
endmodule

// File: rtl/t1_alarm_mon.sv
module t1_alarm_mon #(
  parameter int CHANNELS    = 24,
  parameter int SLOT_BITS   = 8,
  parameter int YEL_BIT     = 2,
  parameter int FDL_RUN     = 8,
  parameter int BLUE_FRAMES = 2,
  localparam int SLOT_W     = $clog2(CHANNELS),
  localparam int POS_W      = $clog2(SLOT_BITS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_vld,
  input  logic              rx_bit,
  input  logic              frm_bit,
  input  logic [SLOT_W-1:0] slot_idx,
  input  logic [POS_W-1:0]  bit_pos,
  input  logic              esf_mode,
  input  logic              fdl_pos,
  input  logic              oof,
  output logic              yel_d4,
  output logic              yel_esf,
  output logic              blue
);
  logic frm_end;

  t1am_frame_track u_frm (
    .clk(clk), .rst(rst), .bit_vld(bit_vld), .frm_bit(frm_bit),
    .frm_end(frm_end)
  );

  t1am_d4_yellow #(
    .CHANNELS(CHANNELS), .SLOT_BITS(SLOT_BITS), .YEL_BIT(YEL_BIT)
  ) u_d4 (
    .clk(clk), .rst(rst), .bit_vld(bit_vld), .rx_bit(rx_bit),
    .frm_bit(frm_bit), .frm_end(frm_end), .slot_idx(slot_idx),
    .bit_pos(bit_pos), .esf_mode(esf_mode), .yel(yel_d4)
  );

  t1am_esf_yellow #(.FDL_RUN(FDL_RUN)) u_esf (
    .clk(clk), .rst(rst), .bit_vld(bit_vld), .rx_bit(rx_bit),
    .fdl_pos(fdl_pos), .esf_mode(esf_mode), .yel(yel_esf)
  );

  t1am_blue #(.BLUE_FRAMES(BLUE_FRAMES)) u_blue (
    .clk(clk), .rst(rst), .bit_vld(bit_vld), .rx_bit(rx_bit),
    .frm_bit(frm_bit), .frm_end(frm_end), .oof(oof), .blue(blue)
  );

  // R1: every flag is low on the cycle after reset
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!yel_d4 && !yel_esf && !blue));
endmodule

// File: tb/sim_t1_alarm_mon.sv
module sim_t1_alarm_mon;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_vld = 1'b0, rx_bit = 1'b0, frm_bit = 1'b0;
  logic [4:0] slot_idx = '0;
  logic [2:0] bit_pos = '0;
  logic esf_mode = 1'b0, fdl_pos = 1'b0, oof = 1'b0;
  logic yel_d4, yel_esf, blue;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  t1_alarm_mon u0 (
    .clk(clk), .rst(rst), .bit_vld(bit_vld), .rx_bit(rx_bit),
    .frm_bit(frm_bit), .slot_idx(slot_idx), .bit_pos(bit_pos),
    .esf_mode(esf_mode), .fdl_pos(fdl_pos), .oof(oof),
    .yel_d4(yel_d4), .yel_esf(yel_esf), .blue(blue)
  );

  // Reference model state, built from the requirements.
  bit m_started, m_cur_ones, m_cur_one2, m_d4, m_esf, m_blue;
  int m_cnt, m_run, m_fill, m_gap, frame_no, fdl_ptr;
  bit [15:0] m_hist;
  bit fdl_in_d4;
  int fdl_src; // 0 alarm pattern, 1 alternating, 2 random

  task automatic chk(input string tag, input logic got, input bit exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b (frame %0d)", tag, got, exp, frame_no);
    end
  endtask

  task automatic model_reset();
    m_started = 0; m_cur_ones = 0; m_cur_one2 = 0; m_d4 = 0; m_esf = 0;
    m_blue = 0; m_cnt = 0; m_run = 0; m_fill = 0; m_gap = 0; m_hist = '0;
  endtask

  task automatic model_bit(input bit b, input bit f, input bit fdl,
                           input int pos, input bit esf, input bit o);
    if (!b) begin m_run = 0; m_blue = 0; end
    if (f) begin
      if (m_started && b) m_run = m_cur_ones ? ((m_run < 2) ? m_run + 1 : 2) : 0;
      if (m_started) begin
        if (esf) m_d4 = 0;
        else if (m_cur_one2) m_d4 = 0;
        else if (m_cnt == 24) m_d4 = 1;
      end
      m_cur_ones = b; m_cur_one2 = 0; m_cnt = 0; m_started = 1;
    end else begin
      m_cur_ones = m_cur_ones & b;
      if (pos == 1) begin m_cnt++; m_cur_one2 = m_cur_one2 | b; end
    end
    if (esf) m_d4 = 0;
    if (!esf) begin
      m_hist = '0; m_fill = 0; m_gap = 0; m_esf = 0;
    end else if (fdl) begin
      m_hist = {m_hist[14:0], b};
      if (m_fill < 16) m_fill++;
      if (m_fill == 16 && m_hist == 16'hFF00) begin m_esf = 1; m_gap = 0; end
      else begin
        if (m_gap < 16) m_gap++;
        if (m_gap == 16) m_esf = 0;
      end
    end
    if (m_run == 2 && o) m_blue = 1;
  endtask

  function automatic bit next_fdl();
    bit v;
    case (fdl_src)
      0: v = ((fdl_ptr % 16) < 8);
      1: v = fdl_ptr[0];
      default: v = 1'($urandom);
    endcase
    fdl_ptr++;
    return v;
  endfunction

  // kind: 0 all ones, 1 bit 2 zero everywhere, 2 random with one bit 2 set, 3 random
  task automatic send_frame(input int kind, input bit esf, input bit o, input int zpos,
                            input string t_d4, input string t_esf, input string t_blue);
    int force_ch;
    force_ch = int'($urandom % 24);
    for (int i = 0; i < 193; i++) begin
      bit b, f, fdl;
      int ch, pos;
      f = (i == 0); fdl = 0; ch = 0; pos = 0;
      if (f) begin
        fdl = frame_no[0] && (esf || fdl_in_d4);
        b = fdl ? next_fdl() : ((kind == 0) ? 1'b1 : 1'($urandom));
      end else begin
        ch = (i - 1) / 8; pos = (i - 1) % 8;
        case (kind)
          0: b = 1'b1;
          1: b = (pos == 1) ? 1'b0 : 1'($urandom);
          2: b = (pos == 1 && ch == force_ch) ? 1'b1 : 1'($urandom);
          default: b = 1'($urandom);
        endcase
      end
      if (i == zpos) b = 1'b0;
      bit_vld = 1'b1; rx_bit = b; frm_bit = f; fdl_pos = fdl;
      slot_idx = 5'(ch); bit_pos = 3'(pos); esf_mode = esf; oof = o;
      @(negedge clk);
      model_bit(b, f, fdl, pos, esf, o);
      if (i == zpos) chk("R10", blue, 1'b0);
    end
    bit_vld = 1'b0; frm_bit = 1'b0; fdl_pos = 1'b0;
    @(negedge clk);
    if (m_run == 2 && o) m_blue = 1;
    chk(t_d4, yel_d4, m_d4);
    chk(t_esf, yel_esf, m_esf);
    chk(t_blue, blue, m_blue);
    frame_no++;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'd1931));
    model_reset();
    frame_no = 0; fdl_ptr = 0; fdl_in_d4 = 0; fdl_src = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", yel_d4, 1'b0); chk("R1", yel_esf, 1'b0); chk("R1", blue, 1'b0);

    // D4 yellow set, clear, set again
    send_frame(3, 0, 0, -1, "R2", "R7", "R9");
    send_frame(1, 0, 0, -1, "R2", "R7", "R9");
    send_frame(1, 0, 0, -1, "R2", "R7", "R9");
    send_frame(1, 0, 0, -1, "R2", "R7", "R9");
    send_frame(2, 0, 0, -1, "R3", "R7", "R9");
    send_frame(1, 0, 0, -1, "R3", "R7", "R9");
    send_frame(1, 0, 0, -1, "R2", "R7", "R9");

    // Data-link pattern offered in D4 mode must be ignored
    fdl_in_d4 = 1; fdl_src = 0; fdl_ptr = 0;
    for (int k = 0; k < 36; k++) send_frame(1, 0, 0, -1, "R2", "R7", "R9");
    fdl_in_d4 = 0;

    // ESF mode: D4 flag held low, pattern raises ESF yellow
    fdl_ptr = 0;
    for (int k = 0; k < 36; k++) send_frame(1, 1, 0, -1, "R4", "R5", "R9");
    // no pattern: ESF yellow drops
    fdl_src = 1;
    for (int k = 0; k < 36; k++) send_frame(3, 1, 0, -1, "R4", "R6", "R9");
    // pattern again, then leave ESF and return: fresh bits required
    fdl_src = 0; fdl_ptr = 0;
    for (int k = 0; k < 34; k++) send_frame(3, 1, 0, -1, "R4", "R5", "R9");
    send_frame(3, 0, 0, -1, "R3", "R7", "R9");
    send_frame(3, 1, 0, -1, "R4", "R7", "R9");
    send_frame(3, 1, 0, -1, "R4", "R7", "R9");

    // Blue: all ones while in frame, then out of frame
    for (int k = 0; k < 3; k++) send_frame(0, 0, 0, -1, "R2", "R7", "R9");
    send_frame(0, 0, 1, -1, "R2", "R7", "R8");
    send_frame(0, 0, 1, 100, "R2", "R7", "R10");
    send_frame(0, 0, 1, -1, "R2", "R7", "R8");
    send_frame(0, 0, 1, -1, "R2", "R7", "R8");
    send_frame(0, 0, 1, -1, "R2", "R7", "R8");
    send_frame(0, 0, 1, 0, "R2", "R7", "R10");
    send_frame(0, 0, 1, 192, "R2", "R7", "R10");
    send_frame(0, 0, 1, -1, "R2", "R7", "R8");
    send_frame(0, 0, 1, -1, "R2", "R7", "R8");

    // Random mix
    for (int k = 0; k < 24; k++) begin
      int kd; bit o; int z;
      kd = int'($urandom % 4);
      o = 1'($urandom);
      z = ($urandom % 4 == 0) ? int'($urandom % 193) : -1;
      fdl_src = 2;
      send_frame(kd, 0, o, z, "R3", "R7", "R8");
    end

    // Reset in the middle of an alarm
    send_frame(0, 0, 1, -1, "R2", "R7", "R8");
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    model_reset();
    chk("R1", yel_d4, 1'b0); chk("R1", yel_esf, 1'b0); chk("R1", blue, 1'b0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule